// File: doc/BRIEF.md
# Exclusive Victim Cache

This block is a small set-associative second-level store that only holds lines pushed out of a first-level cache. It never fills from memory. A first-level eviction arrives on the victim stream and is written into its set. The first level queries the store with a lookup. On a hit the line is returned and removed from this level, so a line never lives in both levels at once. Every lookup, hit or miss, is answered a fixed number of cycles after the request. The default is 9 cycles.

When a victim arrives and its set has no free way, the least recently inserted line of that set is pushed out. A flag stored with each line decides what happens to it. A line marked as shared (usable by another core) leaves on the overflow stream toward a shared next level. An unmarked line is simply dropped. Recency is updated only by insertion. A victim whose address is already present overwrites that line and makes it the most recent.

The victim stream and the overflow stream use valid/ready handshakes. A victim is taken on a cycle where `vic_valid` and `vic_ready` are both high. `vic_ready` is low while an overflow line waits to be accepted. An overflow line stays on `ovf_valid`, `ovf_addr` and `ovf_data`, unchanged, until a cycle with `ovf_ready` high. Lookups and responses carry no back-pressure. Addresses are line addresses: the low bits select the set and the rest form the tag.

Top module: `excl_victim_cache`

## Requirements
- R1: A lookup presented in cycle t produces exactly one response cycle, with `rsp_valid` high in cycle t+LATENCY (default 9) and low in cycles t+1 to t+LATENCY-1.
- R2: A lookup hit returns `rsp_hit`=1 and the full 64-byte line that was last inserted for that address.
- R3: After a lookup hit, the line is no longer held: a later lookup of the same address returns `rsp_hit`=0.
- R4: A lookup miss returns `rsp_hit`=0 and allocates nothing, so a repeated lookup of that address also misses.
- R5: Up to WAYS lines that map to one set are held together, and inserting into a set with a free way neither drops nor forwards any line.
- R6: Inserting a new address into a full set removes the line of that set whose last insertion is oldest.
- R7: Inserting an address that is already present replaces its data and flag and makes it the most recent line of its set.
- R8: A removed line whose shared flag is 1 appears on the overflow port with its own line address and data. A removed line whose flag is 0 never appears there.
- R9: While `ovf_valid` is high and `ovf_ready` is low, the overflow outputs hold steady, `vic_ready` is low and no victim is taken. One cycle with `ovf_ready` high clears `ovf_valid` and raises `vic_ready`.
- R10: A victim taken in the same cycle as a lookup of the same address makes that lookup a hit with the incoming data, and the line is not retained.
- R11: After reset, `vic_ready`=1, `ovf_valid`=0, `rsp_valid`=0, and every lookup misses.
- R12: When a lookup hits in the same cycle as a victim is taken into the same full set, the victim takes the way freed by the hit and no line is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vic_valid | input | 1 | Victim line offered |
| vic_ready | output | 1 | Victim can be taken this cycle |
| vic_addr | input | ADDR_W | Line address of the victim |
| vic_data | input | LINE_BITS | Victim line contents |
| vic_shared | input | 1 | Victim may be used by another core |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Line address to look up |
| rsp_valid | output | 1 | Lookup response, LATENCY cycles after request |
| rsp_hit | output | 1 | Response found the line |
| rsp_data | output | LINE_BITS | Line returned on a hit, zero on a miss |
| ovf_valid | output | 1 | Removed shared line waiting for the next level |
| ovf_ready | input | 1 | Next level accepts the overflow line |
| ovf_addr | output | ADDR_W | Line address of the overflow line |
| ovf_data | output | LINE_BITS | Contents of the overflow line |

## Verification
Lookups are tried against lines inserted into the same set and into different sets, against addresses never inserted, and against lines already handed back. These cases separate a real hit from stale tag matching and from lines that are allocated on a miss or survive a hit. A set is filled and then overflowed with and without a prior re-insertion, and with shared and unshared victims. This shows whether eviction follows insertion recency and whether the flag alone picks forwarding or dropping. Same-cycle pairs are also driven: an insert with a lookup of the same address, and an insert with a hit into the same full set. They expose a missing bypass, and a replacement that ignores the way freed in that cycle. The overflow port is held stalled while a victim is offered, to check that nothing is taken during back-pressure.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // What the insert side does with the victim in a given cycle
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_BYPASS  = 2'd1,
    ACT_FILL    = 2'd2,
    ACT_REPLACE = 2'd3
  } ins_act_e;

endpackage

// File: rtl/evc_way_match.sv
module evc_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22
) (
  input  logic [WAYS-1:0]             valid_row,
  input  logic [WAYS-1:0][TAG_W-1:0]  tag_row,
  input  logic [TAG_W-1:0]            tag_in,
  output logic [WAYS-1:0]             hit_mask
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_mask[w] = valid_row[w] && (tag_row[w] == tag_in);
  end

endmodule

// File: rtl/evc_lru.sv
module evc_lru #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WAY_W-1:0] lru_way
);

  // Per-set age rank: 0 = most recent, WAYS-1 = oldest (WAYS is a power of two)
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0]            lru_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign lru_mask[w] = (age_q[rd_set][w] == WAY_W'(WAYS-1));
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (lru_mask[w]) lru_way = WAY_W'(w);
  end

  // R6: the ranks of a set stay a permutation, so exactly one way is oldest
  a_r6_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lru_mask) == 1);

endmodule

// File: rtl/evc_resp_pipe.sv
module evc_resp_pipe #(
  parameter int LATENCY   = 9,
  parameter int LINE_BITS = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_hit,
  input  logic [LINE_BITS-1:0] in_data,
  output logic                 out_valid,
  output logic                 out_hit,
  output logic [LINE_BITS-1:0] out_data
);

  logic [LATENCY-1:0]   vld_q;
  logic [LATENCY-1:0]   hit_q;
  logic [LINE_BITS-1:0] dat_q [LATENCY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      hit_q <= '0;
    end else begin
      vld_q[0] <= in_valid;
      hit_q[0] <= in_hit;
      for (int i = 1; i < LATENCY; i++) begin
        vld_q[i] <= vld_q[i-1];
        hit_q[i] <= hit_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    dat_q[0] <= in_data;
    for (int i = 1; i < LATENCY; i++)
      dat_q[i] <= dat_q[i-1];
  end

  assign out_valid = vld_q[LATENCY-1];
  assign out_hit   = hit_q[LATENCY-1];
  assign out_data  = dat_q[LATENCY-1];

endmodule

// File: rtl/excl_victim_cache.sv
module excl_victim_cache
  import evc_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int LINE_BITS = 512,
  parameter int WAYS      = 4,
  parameter int SETS      = 16,
  parameter int LATENCY   = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vic_valid,
  output logic                 vic_ready,
  input  logic [ADDR_W-1:0]    vic_addr,
  input  logic [LINE_BITS-1:0] vic_data,
  input  logic                 vic_shared,
  input  logic                 lk_valid,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [LINE_BITS-1:0] rsp_data,
  output logic                 ovf_valid,
  input  logic                 ovf_ready,
  output logic [ADDR_W-1:0]    ovf_addr,
  output logic [LINE_BITS-1:0] ovf_data
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int PND_W = $clog2(LATENCY + 2) + 1;

  // Line state
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0]            shr_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [LINE_BITS-1:0]       dat_q [SETS][WAYS];

  // Overflow holding register
  logic                 ovf_vld_q;
  logic [ADDR_W-1:0]    ovf_addr_q;
  logic [LINE_BITS-1:0] ovf_dat_q;

  // Lookup side
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  lk_hmask;
  logic [WAY_W-1:0] lk_way;
  logic             lk_hit;

  // Insert side
  logic [IDX_W-1:0] vic_idx;
  logic [TAG_W-1:0] vic_tag;
  logic [WAYS-1:0]  vic_hmask;
  logic [WAY_W-1:0] vic_hit_way;
  logic [WAYS-1:0]  ins_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] lru_way;
  logic [WAY_W-1:0] ins_way;
  logic             vic_fire;
  logic             bypass;
  logic             evict_fwd;
  ins_act_e         act;

  // Response path inputs
  logic                 pipe_hit;
  logic [LINE_BITS-1:0] pipe_data;

  assign lk_idx   = lk_addr[IDX_W-1:0];
  assign lk_tag   = lk_addr[ADDR_W-1:IDX_W];
  assign vic_idx  = vic_addr[IDX_W-1:0];
  assign vic_tag  = vic_addr[ADDR_W-1:IDX_W];

  assign vic_ready = !ovf_vld_q;
  assign vic_fire  = vic_valid && vic_ready;
  assign bypass    = lk_valid && vic_fire && (vic_addr == lk_addr);

  evc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid_row (vld_q[lk_idx]),
    .tag_row   (tag_q[lk_idx]),
    .tag_in    (lk_tag),
    .hit_mask  (lk_hmask)
  );

  evc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_vic_match (
    .valid_row (vld_q[vic_idx]),
    .tag_row   (tag_q[vic_idx]),
    .tag_in    (vic_tag),
    .hit_mask  (vic_hmask)
  );

  evc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  ((act == ACT_FILL) || (act == ACT_REPLACE)),
    .touch_set (vic_idx),
    .touch_way (ins_way),
    .rd_set    (vic_idx),
    .lru_way   (lru_way)
  );

  // Way selection from one-hot masks; free search favours the lowest way
  always_comb begin
    lk_way      = '0;
    vic_hit_way = '0;
    free_way    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hmask[w])  lk_way      = WAY_W'(w);
      if (vic_hmask[w]) vic_hit_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (ins_free[w]) free_way = WAY_W'(w);
  end

  assign lk_hit = |lk_hmask;

  // A hit in the victim's set this cycle frees its way for the victim
  always_comb begin
    ins_free = ~vld_q[vic_idx];
    if (lk_valid && (lk_idx == vic_idx))
      ins_free = ins_free | lk_hmask;
  end

  always_comb begin
    act     = ACT_NONE;
    ins_way = '0;
    if (vic_fire) begin
      if (bypass) begin
        act = ACT_BYPASS;
      end else if (|vic_hmask) begin
        act     = ACT_FILL;
        ins_way = vic_hit_way;
      end else if (|ins_free) begin
        act     = ACT_FILL;
        ins_way = free_way;
      end else begin
        act     = ACT_REPLACE;
        ins_way = lru_way;
      end
    end
  end

  assign evict_fwd = (act == ACT_REPLACE) && shr_q[vic_idx][lru_way];

  // Line state update: hit invalidation first, insertion overrides
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        shr_q[s] <= '0;
      end
    end else begin
      if (lk_valid && lk_hit)
        vld_q[lk_idx][lk_way] <= 1'b0;
      if ((act == ACT_FILL) || (act == ACT_REPLACE)) begin
        vld_q[vic_idx][ins_way] <= 1'b1;
        shr_q[vic_idx][ins_way] <= vic_shared;
      end
    end
  end

  always_ff @(posedge clk) begin
    if ((act == ACT_FILL) || (act == ACT_REPLACE)) begin
      tag_q[vic_idx][ins_way] <= vic_tag;
      dat_q[vic_idx][ins_way] <= vic_data;
    end
  end

  // Overflow register: loaded only while empty, since vic_ready needs it empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_vld_q <= 1'b0;
    end else if (evict_fwd) begin
      ovf_vld_q <= 1'b1;
    end else if (ovf_ready) begin
      ovf_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (evict_fwd) begin
      ovf_addr_q <= {tag_q[vic_idx][lru_way], vic_idx};
      ovf_dat_q  <= dat_q[vic_idx][lru_way];
    end
  end

  assign ovf_valid = ovf_vld_q;
  assign ovf_addr  = ovf_addr_q;
  assign ovf_data  = ovf_dat_q;

  // Response source: bypassed victim, stored line, or zero on a miss
  always_comb begin
    pipe_hit  = bypass || lk_hit;
    pipe_data = '0;
    if (bypass)
      pipe_data = vic_data;
    else if (lk_hit)
      pipe_data = dat_q[lk_idx][lk_way];
  end

  evc_resp_pipe #(.LATENCY(LATENCY), .LINE_BITS(LINE_BITS)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (lk_valid),
    .in_hit    (pipe_hit),
    .in_data   (pipe_data),
    .out_valid (rsp_valid),
    .out_hit   (rsp_hit),
    .out_data  (rsp_data)
  );

  // Outstanding lookups, used only by the checks below
  logic [PND_W-1:0] pend_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= '0;
    else
      pend_q <= pend_q + PND_W'(lk_valid) - PND_W'(rsp_valid);
  end

  // R1: a response is never produced without a pending lookup
  a_r1_rsp_has_request: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (pend_q != '0));

  // R1: no more lookups in flight than the pipeline depth
  a_r1_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PND_W'(LATENCY));

  // R3: exclusivity keeps at most one copy of an address in a set
  a_r3_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($countones(lk_hmask) <= 1));

  // R9: a stalled overflow line holds still
  a_r9_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_valid && !ovf_ready) |=>
      (ovf_valid && $stable(ovf_addr) && $stable(ovf_data)));

  // R5/R12: an insert that finds a free way never produces an overflow line
  a_r12_free_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_ready && (|ins_free)) |=> !ovf_valid);

endmodule

// File: tb/excl_victim_cache_tb.sv
module excl_victim_cache_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 26;
  localparam int LB   = 512;
  localparam int LAT  = 9;
  localparam int NV   = 10;

  typedef struct packed {
    logic          lk;    // 1 = lookup, 0 = insert
    logic [AW-1:0] addr;
    logic [7:0]    seed;
    logic          sh;
    logic          hit;
  } vec_t;

  // Sets are the low 4 address bits (16 sets)
  localparam vec_t VECS [NV] = '{
    '{1'b0, 26'h15, 8'h11, 1'b0, 1'b0},
    '{1'b0, 26'h25, 8'h22, 1'b0, 1'b0},
    '{1'b1, 26'h15, 8'h11, 1'b0, 1'b1},
    '{1'b1, 26'h15, 8'h00, 1'b0, 1'b0},
    '{1'b1, 26'h99, 8'h00, 1'b0, 1'b0},
    '{1'b1, 26'h99, 8'h00, 1'b0, 1'b0},
    '{1'b1, 26'h25, 8'h22, 1'b0, 1'b1},
    '{1'b1, 26'h25, 8'h00, 1'b0, 1'b0},
    '{1'b0, 26'h39, 8'h33, 1'b1, 1'b0},
    '{1'b1, 26'h39, 8'h33, 1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vic_valid = 1'b0;
  logic          vic_ready;
  logic [AW-1:0] vic_addr = '0;
  logic [LB-1:0] vic_data = '0;
  logic          vic_shared = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          rsp_valid;
  logic          rsp_hit;
  logic [LB-1:0] rsp_data;
  logic          ovf_valid;
  logic          ovf_ready = 1'b1;
  logic [AW-1:0] ovf_addr;
  logic [LB-1:0] ovf_data;

  int tests = 0;
  int fails = 0;
  int ovf_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_victim_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_addr(vic_addr),
    .vic_data(vic_data), .vic_shared(vic_shared),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .ovf_valid(ovf_valid), .ovf_ready(ovf_ready),
    .ovf_addr(ovf_addr), .ovf_data(ovf_data)
  );

  always @(posedge clk)
    if (rst_n && ovf_valid && ovf_ready) ovf_cnt++;

  function automatic logic [LB-1:0] mk(input logic [7:0] s);
    return {(LB/8){s}};
  endfunction

  task automatic chk(input string req, input logic [LB-1:0] act, input logic [LB-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; checks the response window of a lookup
  task automatic op(input bit lk, input logic [AW-1:0] la, input bit ins,
                    input logic [AW-1:0] ia, input logic [7:0] sd, input bit sh,
                    input bit eh, input logic [7:0] es, input string req);
    if (ins) while (!vic_ready) @(negedge clk);
    lk_valid = lk; lk_addr = la;
    vic_valid = ins; vic_addr = ia; vic_data = mk(sd); vic_shared = sh;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0; vic_valid = 1'b0;
    if (lk) begin
      for (int k = 1; k <= LAT; k++) begin
        if (k > 1) @(negedge clk);
        if (k < LAT) chk({req, " R1 early rsp_valid"}, LB'(rsp_valid), '0);
      end
      chk({req, " R1 rsp_valid"}, LB'(rsp_valid), LB'(1));
      chk({req, " rsp_hit"}, LB'(rsp_hit), LB'(eh));
      if (eh) chk({req, " rsp_data"}, rsp_data, mk(es));
      @(negedge clk);
      chk({req, " R1 single pulse"}, LB'(rsp_valid), '0);
    end
  endtask

  task automatic ins(input logic [AW-1:0] a, input logic [7:0] sd, input bit sh);
    op(1'b0, '0, 1'b1, a, sd, sh, 1'b0, 8'h00, "insert");
  endtask

  task automatic look(input logic [AW-1:0] a, input bit eh, input logic [7:0] es, input string req);
    op(1'b1, a, 1'b0, '0, 8'h00, 1'b0, eh, es, req);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 vic_ready", LB'(vic_ready), LB'(1));
    chk("R11 ovf_valid", LB'(ovf_valid), '0);
    chk("R11 rsp_valid", LB'(rsp_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    look(26'h15, 1'b0, 8'h00, "R11 empty lookup");

    // Table: R2 hit data, R3 removal on hit, R4 miss without allocation
    for (int i = 0; i < NV; i++)
      op(VECS[i].lk, VECS[i].addr, !VECS[i].lk, VECS[i].addr, VECS[i].seed,
         VECS[i].sh, VECS[i].hit, VECS[i].seed, "R2 R3 R4 table");

    // R5 R6 R7 R8: fill set 3, refresh 0x13, overflow drops unshared 0x23
    base = ovf_cnt;
    ins(26'h13, 8'h31, 1'b1);
    ins(26'h23, 8'h32, 1'b0);
    ins(26'h33, 8'h33, 1'b0);
    ins(26'h43, 8'h34, 1'b0);
    chk("R5 no overflow on fill", LB'(ovf_cnt - base), '0);
    ins(26'h13, 8'h5A, 1'b1);
    ins(26'h53, 8'h35, 1'b0);
    chk("R8 unshared dropped", LB'(ovf_valid), '0);
    chk("R8 no forward count", LB'(ovf_cnt - base), '0);
    look(26'h23, 1'b0, 8'h00, "R6 oldest removed");
    look(26'h13, 1'b1, 8'h5A, "R7 refreshed line");
    look(26'h33, 1'b1, 8'h33, "R5 way kept");
    look(26'h43, 1'b1, 8'h34, "R5 way kept");
    look(26'h53, 1'b1, 8'h35, "R6 new line");

    // R8 R9: shared line forwarded and held under back-pressure
    ovf_ready = 1'b0;
    base = ovf_cnt;
    ins(26'h17, 8'hA1, 1'b1);
    ins(26'h27, 8'hA2, 1'b0);
    ins(26'h37, 8'hA3, 1'b0);
    ins(26'h47, 8'hA4, 1'b0);
    ins(26'h57, 8'hA5, 1'b0);
    chk("R8 ovf_valid", LB'(ovf_valid), LB'(1));
    chk("R8 ovf_addr", LB'(ovf_addr), LB'(26'h17));
    chk("R8 ovf_data", ovf_data, mk(8'hA1));
    chk("R9 vic_ready low", LB'(vic_ready), '0);
    vic_valid = 1'b1; vic_addr = 26'h67; vic_data = mk(8'hA6); vic_shared = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9 held valid", LB'(ovf_valid), LB'(1));
      chk("R9 held addr", LB'(ovf_addr), LB'(26'h17));
      chk("R9 ready stays low", LB'(vic_ready), '0);
    end
    vic_valid = 1'b0;
    ovf_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", LB'(ovf_valid), '0);
    chk("R9 ready back", LB'(vic_ready), LB'(1));
    chk("R9 one transfer", LB'(ovf_cnt - base), LB'(1));
    look(26'h67, 1'b0, 8'h00, "R9 stalled victim not taken");
    look(26'h17, 1'b0, 8'h00, "R6 forwarded line gone");
    look(26'h57, 1'b1, 8'hA5, "R6 new line");

    // R10: same-cycle insert and lookup of one address
    op(1'b1, 26'h1A, 1'b1, 26'h1A, 8'h77, 1'b1, 1'b1, 8'h77, "R10 bypass");
    look(26'h1A, 1'b0, 8'h00, "R10 not retained");

    // R12: hit frees a way used by a same-cycle insert into the full set
    base = ovf_cnt;
    ins(26'h1B, 8'hB1, 1'b1);
    ins(26'h2B, 8'hB2, 1'b1);
    ins(26'h3B, 8'hB3, 1'b1);
    ins(26'h4B, 8'hB4, 1'b1);
    op(1'b1, 26'h2B, 1'b1, 26'h5B, 8'hB5, 1'b1, 1'b1, 8'hB2, "R12 hit plus insert");
    chk("R12 no overflow", LB'(ovf_cnt - base), '0);
    look(26'h1B, 1'b1, 8'hB1, "R12 oldest kept");
    look(26'h5B, 1'b1, 8'hB5, "R12 inserted line");
    look(26'h2B, 1'b0, 8'h00, "R12 hit line gone");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule